// File: doc/BRIEF.md
# Two-Level Nesting Interrupt Controller

This block sits beside a processor core and chooses which of six interrupt sources the core services next. Each source has a request line, an enable bit and a one-bit priority level (high or low). The controller keeps a record of which levels are in service, so a new request is granted only when it may preempt the handler that is running. When it grants a request it presents the handler's vector address and a one-cycle acknowledge to the chosen source, one clock after it samples the request.

A state machine tracks nesting. `LV_IDLE` means no handler is in service. `LV_LOW` means a low handler is running. `LV_HIGH` means a high handler is running with nothing below it. `LV_BOTH` means a high handler has preempted a low one. The transitions are:
- grant-low: IDLE→LOW.
- grant-high: IDLE→HIGH or LOW→BOTH.
- return: HIGH→IDLE, BOTH→LOW or LOW→IDLE.

A return strobe (`reti_i`) always pops the highest level in service. Within one level, ties go to the source with the lowest index.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset no level is in service, and `grant_o`, `ack_o` and `vector_o` are all zero until a request is sampled.
- R2: A granted source with index i shows vector 0x0003 + 8·i for i = 0..4 and 0x0053 for i = 5. `ack_o` has only bit i set. Both appear one clock after the request is sampled.
- R3: When several requests at the same level are pending together, the one with the lowest index is granted.
- R4: When high and low requests (`prio_i` bit = 1 means high) are pending in the same cycle, a high request wins.
- R5: A high request is granted while a low handler is in service.
- R6: A low request is never granted while a low handler is in service.
- R7: While a high handler is in service, no request at either level is granted.
- R8: `reti_i` clears the highest level in service. After a return from a high handler that had preempted a low one, the low handler is still in service. A second return frees the controller for low requests.
- R9: With `glb_en_i` low, nothing is granted. A source whose `src_en_i` bit is low is ignored.
- R10: No grant is issued in a cycle in which `reti_i` is sampled high.
- R11: `grant_o` and `ack_o` last one cycle. A request that is still held after its grant is not granted again while its level blocks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 6 | Pending request per source, index 0 polled first |
| src_en_i | input | 6 | Per-source enable mask |
| prio_i | input | 6 | Per-source level, 1 = high |
| glb_en_i | input | 1 | Global enable for all grants |
| reti_i | input | 1 | Return-from-handler strobe |
| grant_o | output | 1 | One-cycle grant pulse |
| ack_o | output | 6 | One-hot acknowledge to the granted source |
| vector_o | output | 16 | Vector address of the granted source |

## Verification
A corrupted nesting state becomes visible at the first request after the fault. If the state is stuck busy, an expected grant is missing on the next clock. If the state is stuck idle, an extra grant appears, for example a low request accepted under a low handler. A return that pops the wrong level shows up one request later, because a held low request is either granted too early or blocked forever. The bench therefore follows every nesting step with a probe request and checks the very next cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC = 6;
    localparam int IDXW = $clog2(NSRC);
    localparam int VECW = 16;
    localparam int NLVL = 2;

    typedef enum logic [1:0] {
        LV_IDLE = 2'd0,
        LV_LOW  = 2'd1,
        LV_HIGH = 2'd2,
        LV_BOTH = 2'd3
    } lvl_state_t;

    // Vectors are spaced 8 bytes apart; the last source sits at a fixed far slot.
    function automatic logic [VECW-1:0] vec_of(input int idx);
        if (idx == NSRC - 1) return VECW'(16'h0053);
        return VECW'(3 + 8 * idx);
    endfunction
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N = 6,
    parameter int W = 3
) (
    input  logic [N-1:0] mask_i,
    output logic         found_o,
    output logic [W-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                found_o = 1'b1;
                idx_o   = W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_lvl_fsm.sv
module irq_lvl_fsm
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       glb_en_i,
    input  logic       hi_pend_i,
    input  logic       lo_pend_i,
    input  logic       reti_i,
    output logic       take_hi_o,
    output logic       take_lo_o,
    output lvl_state_t state_o
);
    lvl_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LV_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        take_hi_o = 1'b0;
        take_lo_o = 1'b0;
        st_d      = st_q;
        unique case (st_q)
            LV_IDLE: begin
                if (!reti_i && glb_en_i && hi_pend_i) begin
                    take_hi_o = 1'b1;
                    st_d      = LV_HIGH;
                end else if (!reti_i && glb_en_i && lo_pend_i) begin
                    take_lo_o = 1'b1;
                    st_d      = LV_LOW;
                end
            end
            LV_LOW: begin
                if (reti_i) begin
                    st_d = LV_IDLE;
                end else if (glb_en_i && hi_pend_i) begin
                    take_hi_o = 1'b1;
                    st_d      = LV_BOTH;
                end
            end
            LV_HIGH: if (reti_i) st_d = LV_IDLE;
            LV_BOTH: if (reti_i) st_d = LV_LOW;
        endcase
    end

    assign state_o = st_q;

    // R8
    pop_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LV_BOTH && reti_i) |=> st_q == LV_LOW);
    // R5
    preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LV_LOW && !reti_i && glb_en_i && hi_pend_i) |=> st_q == LV_BOTH);
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] src_en_i,
    input  logic [NSRC-1:0] prio_i,
    input  logic            glb_en_i,
    input  logic            reti_i,
    output logic            grant_o,
    output logic [NSRC-1:0] ack_o,
    output logic [VECW-1:0] vector_o
);
    logic [NSRC-1:0] live;
    logic [NSRC-1:0] lvl_mask [NLVL];
    logic [NLVL-1:0] lvl_found;
    logic [IDXW-1:0] lvl_idx  [NLVL];
    logic            take_hi, take_lo;
    lvl_state_t      state;
    logic [IDXW-1:0] sel_idx;

    assign live        = req_i & src_en_i;
    assign lvl_mask[0] = live & ~prio_i;
    assign lvl_mask[1] = live & prio_i;

    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        irq_pick #(.N(NSRC), .W(IDXW)) u_pick (
            .mask_i (lvl_mask[l]),
            .found_o(lvl_found[l]),
            .idx_o  (lvl_idx[l])
        );
    end

    irq_lvl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .glb_en_i (glb_en_i),
        .hi_pend_i(lvl_found[1]),
        .lo_pend_i(lvl_found[0]),
        .reti_i   (reti_i),
        .take_hi_o(take_hi),
        .take_lo_o(take_lo),
        .state_o  (state)
    );

    assign sel_idx = take_hi ? lvl_idx[1] : lvl_idx[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_o  <= 1'b0;
            ack_o    <= '0;
            vector_o <= '0;
        end else if (take_hi || take_lo) begin
            grant_o  <= 1'b1;
            ack_o    <= NSRC'(1) << sel_idx;
            vector_o <= vec_of(int'(sel_idx));
        end else begin
            grant_o  <= 1'b0;
            ack_o    <= '0;
            vector_o <= '0;
        end
    end

    // R11
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o) && (grant_o == (|ack_o)));
    // R9
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en_i |=> !grant_o);
    // R7
    hi_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LV_HIGH || state == LV_BOTH) |=> !grant_o);
    // R6
    lo_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LV_LOW) |=> (!grant_o || (|(ack_o & $past(prio_i)))));
    // R10
    reti_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i |=> !grant_o);
endmodule

// File: tb/sim_irq_nest_ctrl.sv
module sim_irq_nest_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] req = '0, src_en = '1, prio = '0;
    logic       glb_en = 1'b1, reti = 1'b0;
    logic       grant;
    logic [5:0] ack;
    logic [15:0] vector;
    int nchk = 0, nfail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_nest_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .src_en_i(src_en), .prio_i(prio),
        .glb_en_i(glb_en), .reti_i(reti), .grant_o(grant), .ack_o(ack), .vector_o(vector)
    );

    function automatic logic [15:0] exp_vec(input int i);
        case (i)
            0: return 16'h0003;
            1: return 16'h000B;
            2: return 16'h0013;
            3: return 16'h001B;
            4: return 16'h0023;
            default: return 16'h0053;
        endcase
    endfunction

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic exp_grant(input string rq, input int i);
        chk(rq, 32'(grant), 32'd1);
        chk(rq, 32'(ack), 32'(6'b1 << i));
        chk(rq, 32'(vector), 32'(exp_vec(i)));
    endtask

    task automatic exp_none(input string rq);
        chk(rq, 32'(grant), 32'd0);
        chk(rq, 32'(ack), 32'd0);
    endtask

    task automatic do_reti(input string rq);
        reti = 1'b1;
        step();
        reti = 1'b0;
        exp_none(rq);
    endtask

    task automatic t_reset();
        exp_none("R1 reset");
        chk("R1 vector", 32'(vector), 32'd0);
    endtask

    task automatic t_vectors();
        for (int i = 0; i < 6; i++) begin
            prio = '0; req = 6'(1 << i);
            step(); exp_grant("R2 vector map", i);
            req = '0;
            step(); exp_none("R11 one cycle");
            do_reti("R10 reti");
        end
    endtask

    task automatic t_poll();
        prio = '0; req = 6'b110100;
        step(); exp_grant("R3 low poll", 2);
        req = '0; do_reti("R10");
        prio = '1; req = 6'b101000;
        step(); exp_grant("R3 high poll", 3);
        req = '0; do_reti("R10");
    endtask

    task automatic t_hi_over_lo();
        prio = 6'b100000; req = 6'b100001;
        step(); exp_grant("R4 high wins", 5);
        req = '0; do_reti("R10");
    endtask

    task automatic t_preempt();
        prio = 6'b000100; req = 6'b000001;
        step(); exp_grant("R5 low start", 0);
        req = 6'b000100;
        step(); exp_grant("R5 preempt", 2);
        req = 6'b001000;
        step(); exp_none("R7 nested busy");
        do_reti("R10 pop high");
        step(); exp_none("R8 low still in service");
        do_reti("R10 pop low");
        step(); exp_grant("R8 low freed", 3);
        req = '0; do_reti("R10");
    endtask

    task automatic t_low_no_preempt();
        prio = '0; req = 6'b010000;
        step(); exp_grant("R6 low start", 4);
        req = 6'b010010;
        step(); exp_none("R6 low over low");
        step(); exp_none("R11 held no regrant");
        req = 6'b000010;
        do_reti("R10");
        step(); exp_grant("R8 after return", 1);
        req = '0; do_reti("R10");
    endtask

    task automatic t_high_blocks();
        prio = '1; req = 6'b000001;
        step(); exp_grant("R7 high start", 0);
        req = 6'b111110;
        step(); exp_none("R7 high busy");
        prio = '0;
        step(); exp_none("R7 low under high");
        req = '0; do_reti("R10");
    endtask

    task automatic t_gate();
        prio = '0; glb_en = 1'b0; req = 6'b000001;
        step(); exp_none("R9 global off");
        glb_en = 1'b1; src_en = 6'b111110;
        step(); exp_none("R9 source masked");
        req = 6'b000011;
        step(); exp_grant("R9 mask skip", 1);
        req = '0; src_en = '1; do_reti("R10");
    endtask

    task automatic t_reti_block();
        prio = '0; req = 6'b000001; reti = 1'b1;
        step(); reti = 1'b0;
        exp_none("R10 reti blocks grant");
        step(); exp_grant("R10 next cycle", 0);
        req = '0; do_reti("R10");
    endtask

    initial begin
        #(5.0 * 200000);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        step(); step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_vectors();
        t_poll();
        t_hi_over_lo();
        t_preempt();
        t_low_no_preempt();
        t_high_blocks();
        t_gate();
        t_reti_block();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule